// File: doc/BRIEF.md
# Receive Byte Queue with DMA and PIO Drain

This block is the receive-side byte queue that sits between a serial deserializer and the rest of the system. Each received byte is appended to a circular store. The store can be emptied in one of two ways, chosen by a small control register. In DMA mode, a request/acknowledge pair moves one four-byte unit per handshake. In PIO mode, software pops single bytes through a register-style read strobe.

A DMA unit is always taken from the four-byte group that holds the read pointer. Bytes left over after a PIO drain can therefore put that pointer in the middle of a group. To handle this, the control register carries an alignment enable. When software moves the block from PIO back to DMA with this enable set, the two low bits of the read pointer are cleared. The bytes already read by software in that group are then delivered again at the front of the next DMA unit, and nothing that followed them is skipped. Without the enable, the pointer keeps its offset, and each unit still consumes four pointer steps. Software must then discard the replayed bytes itself, and the bytes after them are lost. This mode is kept so that the two behaviours can be compared.

The same control register can also clear the queue outright.

Top module: `rx_dual_drain_fifo`

## Requirements
- R1: After synchronous reset: `level` = 0, `empty` = 1, `dma_req` = 0, `overflow` = 0, and the drain mode is DMA.
- R2: A byte presented with `rx_valid` is appended when there is room, and `level` rises by one. `empty` is 1 exactly when `level` is 0.
- R3: The queue is full when the write pointer is `DEPTH` (32) ahead of the read pointer with its two low bits cleared. A byte arriving while full is dropped and sets `overflow`. `overflow` stays set until reset or a queue clear.
- R4: In PIO mode, `pio_data` shows the oldest unread byte, and a `pio_rd` pulse while not empty advances the read pointer by one. `pio_rd` has no effect when the queue is empty or when the block is in DMA mode.
- R5: `dma_req` is 1 in DMA mode whenever `level` is 4 or more. `dma_word` carries the group of four slots starting at the read pointer with its two low bits cleared, the lowest slot in bits [7:0]. An acknowledge while requesting advances the read pointer by four.
- R6: In DMA mode, a remainder of fewer than four bytes never raises `dma_req` and stays in the queue.
- R7: A write of the control field `cfg_data` loads its three bits:
  - bit 0 is the drain mode (0 = DMA, 1 = PIO);
  - bit 1 is the alignment enable;
  - bit 2 requests a queue clear.
- R8: A control write that changes the mode from PIO to DMA with bit 1 set clears read-pointer bits [1:0], so `level` grows by the replayed count. A PIO pop in the same cycle is applied before the clearing. For example, with bytes A1 A2 A3 popped and B1..B4 then received, the first unit is 0xB1A3A2A1 and three bytes remain.
- R9: The same change with bit 1 clear keeps the pointer offset. In the example above, the unit is 0xB1A3A2A1 and the queue is then empty.
- R10: A control write with bit 2 set empties the queue, clears `overflow`, discards a byte received in the same cycle, and still loads the mode.
- R11: `dma_ack` while `dma_req` is 0 leaves the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_data | input | 3 | Control value: mode, alignment enable, clear |
| pio_rd | input | 1 | Software pop strobe |
| pio_data | output | 8 | Oldest unread byte |
| dma_req | output | 1 | A full unit is available in DMA mode |
| dma_ack | input | 1 | DMA has taken the presented unit |
| dma_word | output | 32 | Four-byte unit, lowest slot in [7:0] |
| empty | output | 1 | No unread bytes |
| level | output | 6 | Unread byte count |
| overflow | output | 1 | Sticky lost-byte flag |

## Verification
The delicate overlap is a software pop landing in the same cycle as the control write that returns the block to DMA mode with alignment enabled. The pop must advance the pointer first, and the clearing of the low bits then acts on the advanced value. This is provoked by a directed case with the pointer two bytes into a group. It is also provoked by random traffic in which control writes arrive at a low rate while pops are frequent. Every cycle, the resulting `level`, `pio_data` and `dma_word` are judged against a bench model built from R4, R5 and R8.

// File: rtl/rxdd_pkg.sv
// Shared constants and types for the dual-drain receive queue.
// Assumes a DMA unit of four bytes; the alignment logic depends on it.
package rxdd_pkg;
    localparam int UNIT_LSB      = 2;
    localparam int UNIT_BYTES    = 1 << UNIT_LSB;
    localparam int CFG_W         = 3;
    localparam int CFG_MODE_BIT  = 0;
    localparam int CFG_ALIGN_BIT = 1;
    localparam int CFG_CLR_BIT   = 2;

    typedef enum logic {
        DRAIN_DMA = 1'b0,
        DRAIN_PIO = 1'b1
    } drain_mode_t;
endpackage

// File: rtl/rxdd_store.sv
// Byte store for the receive queue: one write port, a byte-wide read of
// the head slot and a unit-wide read of the aligned group holding it.
// Assumes DEPTH is a power of two and a multiple of the unit size.
module rxdd_store
    import rxdd_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          head,
    output logic [UNIT_BYTES*DW-1:0] unit_word
);
    logic [DW-1:0] mem [DEPTH];

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign head = mem[rd_addr];

    // One lane per byte of the unit, lowest slot in the low lane.
    for (genvar l = 0; l < UNIT_BYTES; l++) begin : g_lane
        assign unit_word[l*DW +: DW] = mem[{rd_addr[AW-1:UNIT_LSB], UNIT_LSB'(l)}];
    end
endmodule

// File: rtl/rxdd_ptrs.sv
// Pointer, mode and flag control for the receive queue. Handles
// appends, PIO pops, DMA unit steps, the PIO-to-DMA realignment and
// the queue clear. Assumes pops and acks are only honoured in their mode.
module rxdd_ptrs
    import rxdd_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             pio_rd,
    input  logic             dma_ack,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    rd_addr,
    output logic [PW-1:0]    level,
    output logic             empty,
    output logic             dma_req,
    output logic             overflow
);
    logic [PW-1:0] wr_ptr, rd_ptr_q, rd_next, grp_base, held;
    drain_mode_t   mode_q;
    logic          ovf_q, full, fifo_clr, pop_ok, ack_ok, realign;

    // Occupancy and request flags from the current pointers.
    always_comb begin
        grp_base = {rd_ptr_q[PW-1:UNIT_LSB], {UNIT_LSB{1'b0}}};
        held     = wr_ptr - grp_base;
        full     = (held == PW'(DEPTH));
        level    = wr_ptr - rd_ptr_q;
        empty    = (level == '0);
        dma_req  = (mode_q == DRAIN_DMA) && (level >= PW'(UNIT_BYTES));
    end

    assign fifo_clr = cfg_wr && cfg_data[CFG_CLR_BIT];
    assign wr_en    = rx_valid && !full && !fifo_clr;
    assign pop_ok   = (mode_q == DRAIN_PIO) && pio_rd && !empty;
    assign ack_ok   = dma_req && dma_ack;
    assign realign  = cfg_wr && (mode_q == DRAIN_PIO) && cfg_data[CFG_ALIGN_BIT]
                      && (drain_mode_t'(cfg_data[CFG_MODE_BIT]) == DRAIN_DMA);

    // Next read pointer: consume first, then drop the offset on realign.
    always_comb begin
        rd_next = rd_ptr_q;
        if (pop_ok)      rd_next = rd_ptr_q + PW'(1);
        else if (ack_ok) rd_next = rd_ptr_q + PW'(UNIT_BYTES);
        if (realign)     rd_next[UNIT_LSB-1:0] = '0;
    end

    // Pointer and overflow state, cleared by reset or queue clear.
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_clr) begin
            wr_ptr   <= '0;
            rd_ptr_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + PW'(1);
            if (rx_valid && full) ovf_q <= 1'b1;
            rd_ptr_q <= rd_next;
        end
    end

    // Drain mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= DRAIN_DMA;
        else if (cfg_wr) mode_q <= drain_mode_t'(cfg_data[CFG_MODE_BIT]);
    end

    assign wr_addr  = wr_ptr[AW-1:0];
    assign rd_addr  = rd_ptr_q[AW-1:0];
    assign overflow = ovf_q;

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !fifo_clr |=> overflow);
    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack && !cfg_wr |=> rd_ptr_q == $past(rd_ptr_q) + PW'(UNIT_BYTES));
    a_r4_dma_ignores_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == DRAIN_DMA) && !dma_ack && !cfg_wr |=> $stable(rd_ptr_q));
    a_r8_realign_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && (cfg_data == 3'b010) && (mode_q == DRAIN_PIO) |=> rd_ptr_q[1:0] == 2'b00);
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> empty && !overflow);
endmodule

// File: rtl/rx_dual_drain_fifo.sv
// Receive byte queue drained either by four-byte DMA units or by single
// PIO pops, selected through a three-bit control register. Assumes one
// unit per request/acknowledge handshake.
module rx_dual_drain_fifo
    import rxdd_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [DW-1:0]            rx_byte,
    input  logic                     cfg_wr,
    input  logic [CFG_W-1:0]         cfg_data,
    input  logic                     pio_rd,
    output logic [DW-1:0]            pio_data,
    output logic                     dma_req,
    input  logic                     dma_ack,
    output logic [UNIT_BYTES*DW-1:0] dma_word,
    output logic                     empty,
    output logic [PW-1:0]            level,
    output logic                     overflow
);
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;

    rxdd_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .pio_rd   (pio_rd),
        .dma_ack  (dma_ack),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr),
        .level    (level),
        .empty    (empty),
        .dma_req  (dma_req),
        .overflow (overflow)
    );

    rxdd_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (rx_byte),
        .rd_addr   (rd_addr),
        .head      (pio_data),
        .unit_word (dma_word)
    );
endmodule

// File: tb/rx_dual_drain_fifo_test.sv
module rx_dual_drain_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, cfg_wr = 1'b0, pio_rd = 1'b0, dma_ack = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [2:0]  cfg_data = '0;
    logic [7:0]  pio_data;
    logic        dma_req, empty, overflow;
    logic [31:0] dma_word;
    logic [5:0]  level;

    always #2 clk = ~clk;

    rx_dual_drain_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .pio_rd(pio_rd), .pio_data(pio_data),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_word(dma_word),
        .empty(empty), .level(level), .overflow(overflow)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference state built from the requirements.
    logic [7:0] mm [32];
    logic [5:0] mwr = '0, mrd = '0;
    logic       mmode = 1'b0, movf = 1'b0;

    function automatic logic [5:0] m_level();
        return mwr - mrd;
    endfunction
    function automatic logic m_req();
        return (mmode == 1'b0) && (m_level() >= 6'd4);
    endfunction
    function automatic logic [31:0] m_word();
        logic [4:0] g = {mrd[4:2], 2'b00};
        return {mm[g+5'd3], mm[g+5'd2], mm[g+5'd1], mm[g]};
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One clock: drive, advance model, then compare at the falling edge.
    task automatic step(logic rv, logic [7:0] rb, logic cw, logic [2:0] cd, logic pp, logic ak);
        logic [5:0] nrd;
        logic [5:0] grp;
        rx_valid = rv; rx_byte = rb; cfg_wr = cw; cfg_data = cd; pio_rd = pp; dma_ack = ak;
        grp = {mrd[5:2], 2'b00};
        @(posedge clk);
        if (cw && cd[2]) begin
            mwr = '0; mrd = '0; movf = 1'b0; mmode = cd[0];
        end else begin
            nrd = mrd;
            if (mmode && pp && m_level() != 0) nrd = mrd + 6'd1;
            else if (!mmode && ak && m_req()) nrd = mrd + 6'd4;
            if (rv) begin
                if ((mwr - grp) == 6'd32) movf = 1'b1;
                else begin mm[mwr[4:0]] = rb; mwr = mwr + 6'd1; end
            end
            if (cw && mmode && !cd[0] && cd[1]) nrd[1:0] = 2'b00;
            if (cw) mmode = cd[0];
            mrd = nrd;
        end
        @(negedge clk);
        rx_valid = 0; cfg_wr = 0; pio_rd = 0; dma_ack = 0;
        chk("R2 level", 32'(level), 32'(m_level()));
        chk("R2 empty", 32'(empty), 32'(m_level() == 0));
        chk("R5 dma_req", 32'(dma_req), 32'(m_req()));
        chk("R3 overflow", 32'(overflow), 32'(movf));
        if (m_level() != 0) chk("R4 pio_data", 32'(pio_data), 32'(mm[mrd[4:0]]));
        if (m_req()) chk("R5 dma_word", dma_word, m_word());
    endtask

    task automatic idle(); step(0, 8'h00, 0, 3'b000, 0, 0); endtask
    task automatic push(logic [7:0] b); step(1, b, 0, 3'b000, 0, 0); endtask
    task automatic pop(); step(0, 8'h00, 0, 3'b000, 1, 0); endtask
    task automatic cfg(logic [2:0] v); step(0, 8'h00, 1, v, 0, 0); endtask
    task automatic ack(); step(0, 8'h00, 0, 3'b000, 0, 1); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 level", 32'(level), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 dma_req", 32'(dma_req), 0);
        chk("R1 overflow", 32'(overflow), 0);

        // R6: three bytes in DMA mode never request
        push(8'hA1); push(8'hA2); push(8'hA3);
        chk("R6 remainder", 32'(dma_req), 0);
        // R11: ack without request changes nothing
        ack();
        chk("R11 ack ignored", 32'(level), 3);
        // R7/R4: PIO mode, pop in order
        cfg(3'b001);
        chk("R4 head", 32'(pio_data), 32'h A1);
        pop(); pop(); pop();
        chk("R4 empty after pops", 32'(empty), 1);
        pop();
        chk("R4 pop when empty", 32'(level), 0);
        push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
        // R8: realign on return to DMA
        cfg(3'b010);
        chk("R8 level grows", 32'(level), 7);
        chk("R8 unit", dma_word, 32'hB1A3A2A1);
        ack();
        chk("R8 remainder kept", 32'(level), 3);
        cfg(3'b001);
        chk("R8 replay tail", 32'(pio_data), 32'hB2);

        // R10: clear with a byte in the same cycle
        step(1, 8'hEE, 1, 3'b101, 0, 0);
        chk("R10 cleared", 32'(level), 0);

        // R9: same sequence without the enable
        push(8'hA1); push(8'hA2); push(8'hA3);
        pop(); pop(); pop();
        push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
        cfg(3'b000);
        chk("R9 level", 32'(level), 4);
        chk("R9 unit", dma_word, 32'hB1A3A2A1);
        ack();
        chk("R9 tail lost", 32'(empty), 1);

        // R8: pop and realign in the same cycle
        cfg(3'b101);
        for (int i = 0; i < 6; i++) push(8'(8'h10 + i));
        pop(); pop();
        step(0, 8'h00, 1, 3'b010, 1, 0);
        chk("R8 pop then realign", 32'(level), 6);

        // R3: fill, overflow, aligned full rule
        cfg(3'b101);
        for (int i = 0; i < 35; i++) push(8'(i));
        chk("R3 full level", 32'(level), 32);
        chk("R3 overflow set", 32'(overflow), 1);
        pop();
        push(8'h77);
        chk("R3 group held", 32'(level), 31);
        // R4: PIO pop ignored in DMA mode (no realign)
        cfg(3'b000);
        step(0, 8'h00, 0, 3'b000, 1, 0);
        chk("R4 pop in DMA mode", 32'(level), 31);
        cfg(3'b101);
        chk("R10 overflow cleared", 32'(overflow), 0);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic cw;
            logic [2:0] cd;
            cw = ($urandom % 16) == 0;
            cd = 3'($urandom);
            if (($urandom % 4) != 0) cd[2] = 1'b0;
            step(1'($urandom), 8'($urandom), cw, cd, 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule